// File: doc/BRIEF.md
# UART FIFO Controller with Receive Character Timeout

This block holds the receive and transmit byte queues of a 16550-style serial port and everything that governs them: the FIFO control register with its flush side effects, the receive trigger level, the receive character-timeout timer and the line status bits that depend on queue state (data ready, overrun, break, transmit holding empty, transmitter empty). The bit-level serializer and deserializer sit outside. They talk to the block through a received-byte strobe, a break strobe, a transmit-pop strobe and a shifter-done strobe.

Software reaches the block through a small byte-wide register port with a one-cycle write strobe and a one-cycle read strobe. Read data is combinational and valid during the read strobe. Side effects of a read (pop, flag clears) take effect at the clock edge that ends the strobe. The register map is: address 0 is the data register (a write queues a transmit byte, a read takes the oldest received byte), address 2 is the FIFO control register, and address 5 is the line status register. Other addresses read 0x00 and ignore writes. The frame format bits feed the timeout length. A bit-clock tick input counts bit times.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the status register reads 0x60, the control register reads 0x00, both counts are 0, the trigger level is 1 and FIFO mode is off.
- R2: In FIFO mode each queue holds up to 16 bytes in arrival order. A data read returns the oldest received byte, and returns 0x00 when the receive queue is empty. `txData` shows the oldest transmit byte, and `txPop` removes it.
- R3: Control bits 7:6 set the receive trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R4: A control write with bit 1 set empties the receive queue and clears the timeout-pending flag. Bit 2 set empties the transmit queue. A write that changes bit 0 (FIFO mode) empties both queues whatever bits 1 and 2 hold.
- R5: The control register keeps only bits 7, 6, 3 and 0 (it reads back as the written value AND 0xC9). A write equal to the stored value changes nothing, and the queues are left intact.
- R6: In FIFO mode, every received byte and every data read that leaves the receive queue non-empty restarts a timeout of 4 × (1 + 5 + fmt[1:0] + fmt[3] + 1 + fmt[2]) bit ticks. When it expires with the receive queue non-empty, `timeoutPending` rises.
- R7: Any data-register read clears `timeoutPending`.
- R8: Status bit 0 is 1 while the receive queue is non-empty. A break strobe queues a 0x00 byte and sets status bit 4. Bit 4 clears on a status read or on a data read that empties the receive queue.
- R9: Status bit 5 is 1 while the transmit queue is empty. Status bit 6 sets when the shifter reports done with the transmit queue empty. A data write clears both bits.
- R10: A byte arriving at a full receive queue is dropped and sets status bit 1. A status read clears bit 1.
- R11: With FIFO mode off, each queue holds a single byte and the timeout never runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, valid during regRdEn |
| frameFmt | input | 4 | Frame format: [1:0] data length code, [2] extra stop bit, [3] parity on |
| bitTick | input | 1 | One pulse per bit time |
| rxValid | input | 1 | Received byte strobe |
| rxBreak | input | 1 | Received break strobe |
| rxData | input | 8 | Received byte |
| txPop | input | 1 | Serializer takes the oldest transmit byte |
| txShiftDone | input | 1 | Serializer finished its last character |
| txData | output | 8 | Oldest transmit byte |
| rxCount | output | 5 | Receive queue occupancy |
| txCount | output | 5 | Transmit queue occupancy |
| trigLevel | output | 5 | Decoded receive trigger level |
| timeoutPending | output | 1 | Receive character timeout pending |
| fifoEnabled | output | 1 | FIFO mode active |

## Verification
The assertions assume that at most one register access happens per cycle, so a data read, a data write and a control write never coincide. They also assume that `regAddr` is stable while a strobe is high. The stimulus issues every register access from one task that raises a single strobe for exactly one cycle. Serializer and deserializer strobes are likewise pulsed one at a time, and `bitTick` is held high so the expected timeout expiry edge can be counted exactly.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_FCTL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd5;

  localparam logic [REG_W-1:0] FCTL_KEEP = 8'hC9;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic rxClr;
    logic txPush;
    logic txPop;
    logic txClr;
  } fifoStrobe_t;
endpackage

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] headPtr, tailPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else if (clr) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (push) headPtr <= nextPtr(headPtr);
      if (pop)  tailPtr <= nextPtr(tailPtr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[headPtr] <= wrData;
  end

  assign rdData = (count == '0) ? '0 : mem[tailPtr];

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && !pop && count == CW'(DEPTH)));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && count == '0));
endmodule

// File: rtl/uart_fifo_datapath.sv
module uart_fifo_datapath
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifoStrobe_t      strobe,
  input  logic [REG_W-1:0] rxByte,
  input  logic [REG_W-1:0] txByte,
  output logic [REG_W-1:0] rxHead,
  output logic [REG_W-1:0] txHead,
  output logic [CW-1:0]    rxCnt,
  output logic [CW-1:0]    txCnt
);
  uart_fifo_buf #(.DEPTH(DEPTH), .DW(REG_W)) u_rxBuf (
    .clk(clk), .rst_n(rst_n),
    .push(strobe.rxPush), .pop(strobe.rxPop), .clr(strobe.rxClr),
    .wrData(rxByte), .rdData(rxHead), .count(rxCnt)
  );

  uart_fifo_buf #(.DEPTH(DEPTH), .DW(REG_W)) u_txBuf (
    .clk(clk), .rst_n(rst_n),
    .push(strobe.txPush), .pop(strobe.txPop), .clr(strobe.txClr),
    .wrData(txByte), .rdData(txHead), .count(txCnt)
  );
endmodule

// File: rtl/uart_char_timer.sv
module uart_char_timer #(
  parameter int TIMEOUT_CHARS = 4,
  localparam int MAX_BITS = 12,
  localparam int TW = $clog2(MAX_BITS * TIMEOUT_CHARS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] frameFmt,
  input  logic       bitTick,
  input  logic       restart,
  input  logic       cancel,
  input  logic       clearPend,
  input  logic       rxNonEmpty,
  output logic       pending
);
  logic [3:0]    charBits;
  logic [TW-1:0] loadVal, remain;
  logic          expire;

  // start + 5 base data bits + length code + parity + first stop + extra stop
  assign charBits = 4'd7 + {2'b00, frameFmt[1:0]} + {3'b000, frameFmt[3]}
                  + {3'b000, frameFmt[2]};
  assign loadVal  = TW'(charBits) * TW'(TIMEOUT_CHARS);
  assign expire   = bitTick && (remain == TW'(1)) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      pending <= 1'b0;
    end else if (cancel) begin
      remain  <= '0;
      pending <= 1'b0;
    end else begin
      if (restart)                        remain <= loadVal;
      else if (bitTick && remain != '0)   remain <= remain - TW'(1);
      if (clearPend)                      pending <= 1'b0;
      else if (expire && rxNonEmpty)      pending <= 1'b1;
    end
  end

  p_pend_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(rxNonEmpty));
  p_read_clears_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clearPend |=> !pending);
  p_flush_clears_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!pending && remain == '0));
endmodule

// File: rtl/uart_fifo_control.sv
module uart_fifo_control
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              rxValid,
  input  logic              rxBreak,
  input  logic [REG_W-1:0]  rxDataIn,
  input  logic              txPopReq,
  input  logic              txShiftDone,
  input  logic [CW-1:0]     rxCnt,
  input  logic [CW-1:0]     txCnt,
  input  logic [REG_W-1:0]  rxHead,
  output fifoStrobe_t       strobe,
  output logic [REG_W-1:0]  rxByte,
  output logic [CW-1:0]     trigLevel,
  output logic              fifoEn,
  output logic              tmrRestart,
  output logic              tmrCancel,
  output logic              tmrClearPend
);
  localparam logic [CW-1:0] TRIG_0 = CW'(1);
  localparam logic [CW-1:0] TRIG_1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] TRIG_2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] TRIG_3 = CW'(DEPTH - 2);

  logic [REG_W-1:0] fctlReg, statusByte;
  logic brkFlag, ovrFlag, temtFlag;
  logic dataWr, dataRd, fctlWr, statRd;
  logic fctlChange, enFlip, rxIn, rxPopOk, txPopOk, rxRoom, txRoom, overrun;
  logic [CW-1:0] capacity;

  assign dataWr = regWrEn && regAddr == ADDR_DATA;
  assign dataRd = regRdEn && regAddr == ADDR_DATA;
  assign fctlWr = regWrEn && regAddr == ADDR_FCTL;
  assign statRd = regRdEn && regAddr == ADDR_STAT;

  assign fifoEn   = fctlReg[0];
  assign capacity = fifoEn ? CW'(DEPTH) : CW'(1);

  assign fctlChange = fctlWr && (regWrData != fctlReg);
  assign enFlip     = regWrData[0] ^ fctlReg[0];

  assign rxIn    = rxValid || rxBreak;
  assign rxByte  = rxBreak ? '0 : rxDataIn;
  assign rxPopOk = dataRd && rxCnt != '0;
  assign txPopOk = txPopReq && txCnt != '0;
  assign rxRoom  = (rxCnt < capacity) || rxPopOk;
  assign txRoom  = (txCnt < capacity) || txPopOk;

  always_comb begin
    strobe.rxClr  = fctlChange && (regWrData[1] || enFlip);
    strobe.txClr  = fctlChange && (regWrData[2] || enFlip);
    strobe.rxPush = rxIn && rxRoom && !strobe.rxClr;
    strobe.rxPop  = rxPopOk && !strobe.rxClr;
    strobe.txPush = dataWr && txRoom && !strobe.txClr;
    strobe.txPop  = txPopOk && !strobe.txClr;
  end

  assign overrun = rxIn && !rxRoom && !strobe.rxClr;

  assign tmrRestart   = fifoEn && ((rxIn && !strobe.rxClr) ||
                                   (strobe.rxPop && rxCnt > CW'(1)));
  assign tmrCancel    = strobe.rxClr;
  assign tmrClearPend = dataRd;

  always_comb begin
    unique case (fctlReg[7:6])
      2'b00:   trigLevel = TRIG_0;
      2'b01:   trigLevel = TRIG_1;
      2'b10:   trigLevel = TRIG_2;
      default: trigLevel = TRIG_3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fctlReg  <= '0;
      brkFlag  <= 1'b0;
      ovrFlag  <= 1'b0;
      temtFlag <= 1'b1;
    end else begin
      if (fctlChange) fctlReg <= regWrData & FCTL_KEEP;

      if (rxBreak)
        brkFlag <= 1'b1;
      else if (statRd || (strobe.rxPop && rxCnt == CW'(1) && !strobe.rxPush))
        brkFlag <= 1'b0;

      if (overrun)     ovrFlag <= 1'b1;
      else if (statRd) ovrFlag <= 1'b0;

      if (dataWr)                           temtFlag <= 1'b0;
      else if (txShiftDone && txCnt == '0)  temtFlag <= 1'b1;
    end
  end

  assign statusByte = {1'b0, temtFlag, (txCnt == '0), brkFlag,
                       2'b00, ovrFlag, (rxCnt != '0)};

  always_comb begin
    unique case (regAddr)
      ADDR_DATA: regRdData = rxHead;
      ADDR_FCTL: regRdData = fctlReg;
      ADDR_STAT: regRdData = statusByte;
      default:   regRdData = '0;
    endcase
  end

  p_enflip_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fctlWr && regWrData[0] != fctlReg[0]) |=> (rxCnt == '0 && txCnt == '0));
  p_same_fctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fctlWr && regWrData == fctlReg) |=> $stable(fctlReg));
  p_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dataWr |=> (txCnt != '0 && !temtFlag));
  p_overrun_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovrFlag) |-> ($past(rxCnt) == $past(capacity)));
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TIMEOUT_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [3:0]        frameFmt,
  input  logic              bitTick,
  input  logic              rxValid,
  input  logic              rxBreak,
  input  logic [REG_W-1:0]  rxData,
  input  logic              txPop,
  input  logic              txShiftDone,
  output logic [REG_W-1:0]  txData,
  output logic [CW-1:0]     rxCount,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     trigLevel,
  output logic              timeoutPending,
  output logic              fifoEnabled
);
  fifoStrobe_t      strobe;
  logic [REG_W-1:0] rxByte, rxHead;
  logic             tmrRestart, tmrCancel, tmrClearPend;

  uart_fifo_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxValid(rxValid), .rxBreak(rxBreak), .rxDataIn(rxData),
    .txPopReq(txPop), .txShiftDone(txShiftDone),
    .rxCnt(rxCount), .txCnt(txCount), .rxHead(rxHead),
    .strobe(strobe), .rxByte(rxByte), .trigLevel(trigLevel),
    .fifoEn(fifoEnabled), .tmrRestart(tmrRestart),
    .tmrCancel(tmrCancel), .tmrClearPend(tmrClearPend)
  );

  uart_fifo_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rxByte(rxByte), .txByte(regWrData),
    .rxHead(rxHead), .txHead(txData),
    .rxCnt(rxCount), .txCnt(txCount)
  );

  uart_char_timer #(.TIMEOUT_CHARS(TIMEOUT_CHARS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .frameFmt(frameFmt), .bitTick(bitTick),
    .restart(tmrRestart), .cancel(tmrCancel), .clearPend(tmrClearPend),
    .rxNonEmpty(rxCount != '0), .pending(timeoutPending)
  );
endmodule

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 0, regRdEn = 0, bitTick = 1;
  logic [2:0] regAddr = 0;
  logic [7:0] regWrData = 0, rxData = 0;
  logic [3:0] frameFmt = 4'h3;
  logic rxValid = 0, rxBreak = 0, txPop = 0, txShiftDone = 0;
  logic [7:0] regRdData, txData;
  logic [4:0] rxCount, txCount, trigLevel;
  logic timeoutPending, fifoEnabled;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  uart_fifo_ctrl dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frameFmt(frameFmt), .bitTick(bitTick), .rxValid(rxValid),
    .rxBreak(rxBreak), .rxData(rxData), .txPop(txPop),
    .txShiftDone(txShiftDone), .txData(txData), .rxCount(rxCount),
    .txCount(txCount), .trigLevel(trigLevel),
    .timeoutPending(timeoutPending), .fifoEnabled(fifoEnabled)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every read against the scoreboard queue
  always @(negedge clk) begin
    if (regRdEn) begin
      if (expQ.size() == 0) chk("scoreboard-empty", 1, 0);
      else chk(tagQ.pop_front(), regRdData, expQ.pop_front());
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(int n); repeat (n) step(); endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    regAddr = a; regRdEn = 1; expQ.push_back(exp); tagQ.push_back(tag);
    step(); regRdEn = 0;
  endtask
  task automatic wr(logic [2:0] a, logic [7:0] v);
    regAddr = a; regWrData = v; regWrEn = 1; step(); regWrEn = 0;
  endtask
  task automatic rxPush(logic [7:0] b);
    rxData = b; rxValid = 1; step(); rxValid = 0;
  endtask
  task automatic brk(); rxBreak = 1; step(); rxBreak = 0; endtask
  task automatic popTx(); txPop = 1; step(); txPop = 0; endtask
  task automatic shiftDone(); txShiftDone = 1; step(); txShiftDone = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; step();
    // R1 reset state
    chk("R1 rxCount", rxCount, 0); chk("R1 txCount", txCount, 0);
    chk("R1 trig", trigLevel, 1); chk("R1 fifoEn", fifoEnabled, 0);
    rd(5, 8'h60, "R1 status"); rd(2, 8'h00, "R1 fctl");
    // R11 non-FIFO mode: single byte, overrun R10
    rxPush(8'h11); rxPush(8'h22);
    chk("R11 rx single", rxCount, 1);
    rd(5, 8'h63, "R10 overrun status");
    rd(0, 8'h11, "R11 first kept");
    rd(5, 8'h60, "R10 overrun cleared");
    rxPush(8'h33); idle(60);
    chk("R11 no timeout", timeoutPending, 0);
    rd(0, 8'h33, "R11 data");
    wr(0, 8'h44); wr(0, 8'h55);
    chk("R11 tx single", txCount, 1); chk("R11 txData", txData, 8'h44);
    popTx(); shiftDone();
    rd(5, 8'h60, "R9 idle status");
    // R3 / R5 control register
    wr(2, 8'h01); chk("R3 enabled", fifoEnabled, 1); chk("R3 trig 1", trigLevel, 1);
    wr(2, 8'hFF); rd(2, 8'hC9, "R5 mask"); chk("R3 trig 14", trigLevel, 14);
    wr(2, 8'h41); chk("R3 trig 4", trigLevel, 4);
    wr(2, 8'h81); chk("R3 trig 8", trigLevel, 8);
    wr(2, 8'h01);
    rxPush(8'h10); rxPush(8'h20); rxPush(8'h30);
    wr(2, 8'h01); chk("R5 same write no flush", rxCount, 3);
    wr(2, 8'h03); chk("R4 rx flush", rxCount, 0);
    rd(2, 8'h01, "R5 clear bit not kept");
    // R2 ordering, R10 full
    for (int i = 0; i < 16; i++) rxPush(8'(i * 7 + 3));
    chk("R2 full count", rxCount, 16);
    rxPush(8'hEE); chk("R10 dropped", rxCount, 16);
    rd(5, 8'h63, "R10 overrun set"); rd(5, 8'h61, "R10 overrun cleared");
    for (int i = 0; i < 16; i++) rd(0, 8'(i * 7 + 3), "R2 order");
    rd(0, 8'h00, "R2 empty read"); chk("R2 drained", rxCount, 0);
    for (int i = 0; i < 5; i++) wr(0, 8'(8'h80 + i));
    chk("R2 tx count", txCount, 5);
    rd(5, 8'h00, "R9 busy status");
    for (int i = 0; i < 5; i++) begin
      chk("R2 tx order", txData, 8'h80 + i); popTx();
    end
    rd(5, 8'h20, "R9 thre only");
    shiftDone(); rd(5, 8'h60, "R9 temt set");
    // R4 flush variants
    wr(0, 8'h90); wr(0, 8'h90); wr(0, 8'h90); rxPush(8'h01); rxPush(8'h02);
    wr(2, 8'h05);
    chk("R4 tx flush", txCount, 0); chk("R4 rx kept", rxCount, 2);
    wr(0, 8'h91); wr(2, 8'h00);
    chk("R4 flip rx", rxCount, 0); chk("R4 flip tx", txCount, 0);
    chk("R4 disabled", fifoEnabled, 0);
    wr(2, 8'h01); shiftDone();
    // R6 / R7 timeout, fmt 0x3 -> 10 bits -> 40 ticks
    frameFmt = 4'h3;
    rxPush(8'hA5); idle(39); chk("R6 before 40", timeoutPending, 0);
    idle(1); chk("R6 at 40", timeoutPending, 1);
    rd(0, 8'hA5, "R7 data"); chk("R7 cleared", timeoutPending, 0);
    idle(60); chk("R6 empty no timeout", timeoutPending, 0);
    // fmt 0xF -> 12 bits -> 48 ticks, restart by byte and by read
    frameFmt = 4'hF;
    rxPush(8'h01); rxPush(8'h02);
    idle(47); chk("R6 before 48", timeoutPending, 0);
    idle(1); chk("R6 at 48", timeoutPending, 1);
    rd(0, 8'h01, "R7 read"); chk("R7 read clears", timeoutPending, 0);
    idle(47); chk("R6 read restart early", timeoutPending, 0);
    idle(1); chk("R6 read restart fires", timeoutPending, 1);
    wr(2, 8'h03); chk("R4 flush clears pending", timeoutPending, 0);
    chk("R4 flush rx", rxCount, 0);
    // fmt 0x0 -> 7 bits -> 28 ticks
    frameFmt = 4'h0;
    rxPush(8'h5A); idle(27); chk("R6 before 28", timeoutPending, 0);
    idle(1); chk("R6 at 28", timeoutPending, 1);
    wr(2, 8'h03);
    // R8 break
    brk();
    rd(5, 8'h71, "R8 break status"); rd(5, 8'h61, "R8 status read clears");
    chk("R8 break byte queued", rxCount, 1);
    rd(0, 8'h00, "R8 break byte"); rd(5, 8'h60, "R8 empty");
    brk(); rd(0, 8'h00, "R8 break byte 2");
    rd(5, 8'h60, "R8 emptying read clears");
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule